// File: doc/BRIEF.md
# Critical-Load Fetch Halt Controller

This block decides when the front end should stop fetching because a load that matters is waiting on main memory. Software marks some loads as promising. Each mark carries an expected miss stride. The block keeps a small fully associative table of these loads, keyed by PC, with one execution counter per load. Each time a marked load issues, its counter is compared with its stride. A match predicts that this instance will miss, and the block then remembers the load's tag as predicted-critical.

A later main-memory miss that reports a predicted-critical tag raises `fetch_halt`. The halt stays up until every such outstanding miss has returned. A pipeline flush drops all pending halt state at once. Loads without a mark, misses on tags that were never predicted, and returns for tags that are not outstanding change nothing.

The load-issue, miss and return inputs are one-cycle valid strobes with no ready signal. The block never applies back-pressure and takes at most one event of each kind per cycle. Flush and the halt output are plain level control pins.

Top module: `fetch_halt_ctrl`

## Requirements
- R1: After reset `fetch_halt` is 0, the table holds no loads, and no tag is predicted or outstanding.
- R2: A load issue with `ld_promise` = 0 neither allocates nor updates a table entry, and never makes its tag predicted. A later miss on that tag leaves `fetch_halt` at 0.
- R3: Each entry holds a counter and the stride captured when the entry was allocated. A new entry starts with a count of 0. On every annotated issue of its PC the load is predicted if count equals stride, and the count then becomes 0. Otherwise the count increments. With stride S the predictions land on executions S+1, 2(S+1), and so on.
- R4: `fetch_halt` rises in the cycle after a `mem_miss_vld` whose tag is currently predicted and not already outstanding. That miss consumes the prediction. A miss on any other tag has no effect.
- R5: `fetch_halt` stays at 1 while the miss is outstanding and falls in the cycle after the `mem_ret_vld` for its tag.
- R6: With several qualifying misses outstanding, `fetch_halt` stays at 1 until all of them have returned. A return whose tag is not outstanding is ignored.
- R7: `flush` clears every prediction, every outstanding miss and the pending count, so `fetch_halt` is 0 in the next cycle. Table entries and their counters are kept.
- R8: The table has `ENTRIES` (8) fully associative entries. An issue that misses the table fills the lowest-numbered empty entry. When the table is full it replaces the least recently issued entry, and every annotated issue counts as a use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush; discards pending halt state |
| ld_vld | input | 1 | Load issue strobe |
| ld_pc | input | PC_W | PC of the issuing load |
| ld_tag | input | TAG_W | In-flight tag of the issuing load |
| ld_promise | input | 1 | Software annotation: load is promising |
| ld_stride | input | STRIDE_W | Annotated expected miss stride |
| mem_miss_vld | input | 1 | A load missed to main memory |
| mem_miss_tag | input | TAG_W | Tag of the missing load |
| mem_ret_vld | input | 1 | A main-memory miss has returned |
| mem_ret_tag | input | TAG_W | Tag of the returning load |
| fetch_halt | output | 1 | Fetch must stay stopped |

## Verification
The main function is driven with a zero-stride load followed by a matching miss, a miss on the wrong tag, and an unmarked load that misses. Between them these patterns separate the real halt from a halt on any miss and from a halt on any issue. A stride-2 load missing on every one of four executions shows that only the third execution is predicted and that the counter wraps afterwards. Two overlapping critical misses returned out of order, with a stray return between them, show that the halt ends on the last return and not the first. A flush issued mid-halt, and a table filled and then overflowed after a re-touch, show that flush drops the pending state and that replacement removes the least recently used PC and not the re-touched one.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
  localparam int FHC_PC_W     = 32;
  localparam int FHC_TAG_W    = 4;
  localparam int FHC_STRIDE_W = 4;
  localparam int FHC_ENTRIES  = 8;

  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_HIT   = 2'd1,
    SLOT_FREE  = 2'd2,
    SLOT_EVICT = 2'd3
  } slot_src_e;
endpackage

// File: rtl/fhc_lru.sv
module fhc_lru #(
  parameter  int ENTRIES = 8,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_vld,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  // Each entry holds an age. The ages form a permutation and 0 is the most recent.
  logic [IW-1:0]      age_q [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IW'(i);
    end else if (touch_vld) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == touch_idx)             age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + IW'(1);
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      oldest_vec[i] = (age_q[i] == IW'(ENTRIES - 1));
      if (oldest_vec[i]) victim_idx = IW'(i);
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);  // R8
endmodule

// File: rtl/fhc_stride_table.sv
module fhc_stride_table
  import fhc_pkg::*;
#(
  parameter  int PC_W     = 32,
  parameter  int STRIDE_W = 4,
  parameter  int ENTRIES  = 8,
  localparam int IW       = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_vld,
  input  logic [PC_W-1:0]     lk_pc,
  input  logic [STRIDE_W-1:0] lk_stride,
  output logic                pred
);
  logic [ENTRIES-1:0]  vld_q;
  logic [PC_W-1:0]     pc_q  [ENTRIES];
  logic [STRIDE_W-1:0] str_q [ENTRIES];
  logic [STRIDE_W-1:0] cnt_q [ENTRIES];

  logic [ENTRIES-1:0]  hit_vec;
  logic                hit, any_free;
  logic [IW-1:0]       hit_idx, free_idx, victim_idx, tgt_idx;
  logic [STRIDE_W-1:0] cur_cnt, cur_str;
  slot_src_e           src;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = vld_q[i] && (pc_q[i] == lk_pc);
      if (hit_vec[i]) hit_idx = IW'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
    hit = |hit_vec;
  end

  always_comb begin
    if (!lk_vld)       src = SLOT_NONE;
    else if (hit)      src = SLOT_HIT;
    else if (any_free) src = SLOT_FREE;
    else               src = SLOT_EVICT;
    unique case (src)
      SLOT_HIT:  tgt_idx = hit_idx;
      SLOT_FREE: tgt_idx = free_idx;
      default:   tgt_idx = victim_idx;
    endcase
    cur_cnt = (src == SLOT_HIT) ? cnt_q[hit_idx] : '0;
    cur_str = (src == SLOT_HIT) ? str_q[hit_idx] : lk_stride;
    pred    = (src != SLOT_NONE) && (cur_cnt == cur_str);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pc_q[i]  <= '0;
        str_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (src != SLOT_NONE) begin
      vld_q[tgt_idx] <= 1'b1;
      pc_q[tgt_idx]  <= lk_pc;
      str_q[tgt_idx] <= cur_str;
      cnt_q[tgt_idx] <= pred ? '0 : cur_cnt + STRIDE_W'(1);
    end
  end

  fhc_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_vld (lk_vld),
    .touch_idx (tgt_idx),
    .victim_idx(victim_idx)
  );

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));  // R8

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cnt_chk
      AST_CNT_LE_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[g] |-> cnt_q[g] <= str_q[g]);  // R3
    end
  endgenerate
endmodule

// File: rtl/fhc_halt_tracker.sv
module fhc_halt_tracker #(
  parameter  int TAG_W = 4,
  localparam int NT    = 1 << TAG_W,
  localparam int CW    = $clog2(NT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             pred_vld,
  input  logic [TAG_W-1:0] pred_tag,
  input  logic             miss_vld,
  input  logic [TAG_W-1:0] miss_tag,
  input  logic             ret_vld,
  input  logic [TAG_W-1:0] ret_tag,
  output logic             halt
);
  logic [NT-1:0] pred_q, pred_n;
  logic [NT-1:0] outs_q, outs_n;
  logic [CW-1:0] pend_q, pend_n;
  logic          halt_q;
  logic          miss_qual, ret_match;

  always_comb begin
    miss_qual = miss_vld && pred_q[miss_tag] && !outs_q[miss_tag];
    ret_match = ret_vld && outs_q[ret_tag];
    pred_n = pred_q;
    outs_n = outs_q;
    if (miss_qual) pred_n[miss_tag] = 1'b0;
    if (pred_vld)  pred_n[pred_tag] = 1'b1;
    if (ret_match) outs_n[ret_tag]  = 1'b0;
    if (miss_qual) outs_n[miss_tag] = 1'b1;
    pend_n = pend_q + CW'(miss_qual) - CW'(ret_match);
    if (flush_i) begin
      pred_n = '0;
      outs_n = '0;
      pend_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      outs_q <= '0;
      pend_q <= '0;
      halt_q <= 1'b0;
    end else begin
      pred_q <= pred_n;
      outs_q <= outs_n;
      pend_q <= pend_n;
      halt_q <= (pend_n != '0);
    end
  end

  assign halt = halt_q;

  AST_HALT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_q) |-> $past(miss_qual));  // R4
  AST_HALT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_q) |-> $past(flush_i || ret_match));  // R5
  AST_PEND_TRACKS_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q == CW'($countones(outs_q)));  // R6
  AST_RET_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ret_match |-> pend_q != '0);  // R6
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !halt_q);  // R7
endmodule

// File: rtl/fetch_halt_ctrl.sv
module fetch_halt_ctrl
  import fhc_pkg::*;
#(
  parameter int PC_W     = FHC_PC_W,
  parameter int TAG_W    = FHC_TAG_W,
  parameter int STRIDE_W = FHC_STRIDE_W,
  parameter int ENTRIES  = FHC_ENTRIES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                ld_vld,
  input  logic [PC_W-1:0]     ld_pc,
  input  logic [TAG_W-1:0]    ld_tag,
  input  logic                ld_promise,
  input  logic [STRIDE_W-1:0] ld_stride,
  input  logic                mem_miss_vld,
  input  logic [TAG_W-1:0]    mem_miss_tag,
  input  logic                mem_ret_vld,
  input  logic [TAG_W-1:0]    mem_ret_tag,
  output logic                fetch_halt
);
  logic lk_vld;
  logic pred;

  assign lk_vld = ld_vld && ld_promise;

  fhc_stride_table #(
    .PC_W    (PC_W),
    .STRIDE_W(STRIDE_W),
    .ENTRIES (ENTRIES)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vld   (lk_vld),
    .lk_pc    (ld_pc),
    .lk_stride(ld_stride),
    .pred     (pred)
  );

  fhc_halt_tracker #(.TAG_W(TAG_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush),
    .pred_vld(pred),
    .pred_tag(ld_tag),
    .miss_vld(mem_miss_vld),
    .miss_tag(mem_miss_tag),
    .ret_vld (mem_ret_vld),
    .ret_tag (mem_ret_tag),
    .halt    (fetch_halt)
  );

  AST_UNMARKED_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && !ld_promise) |-> !pred);  // R2
endmodule

// File: tb/tb_fetch_halt_ctrl.sv
module tb_fetch_halt_ctrl;
  localparam int PC_W = 32, TAG_W = 4, STRIDE_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic ld_vld = 1'b0, ld_promise = 1'b0;
  logic [PC_W-1:0] ld_pc = '0;
  logic [TAG_W-1:0] ld_tag = '0, mem_miss_tag = '0, mem_ret_tag = '0;
  logic [STRIDE_W-1:0] ld_stride = '0;
  logic mem_miss_vld = 1'b0, mem_ret_vld = 1'b0;
  logic fetch_halt;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  fetch_halt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_vld(ld_vld), .ld_pc(ld_pc), .ld_tag(ld_tag),
    .ld_promise(ld_promise), .ld_stride(ld_stride),
    .mem_miss_vld(mem_miss_vld), .mem_miss_tag(mem_miss_tag),
    .mem_ret_vld(mem_ret_vld), .mem_ret_tag(mem_ret_tag),
    .fetch_halt(fetch_halt)
  );

  task automatic chk(string req, logic exp);
    n_chk++;
    if (fetch_halt !== exp) begin
      n_fail++;
      $display("FAIL %s: fetch_halt=%b expected %b at %0t", req, fetch_halt, exp, $time);
    end
  endtask

  task automatic issue(logic [PC_W-1:0] pc, logic [TAG_W-1:0] tag, logic prom, logic [STRIDE_W-1:0] s);
    ld_vld = 1'b1; ld_pc = pc; ld_tag = tag; ld_promise = prom; ld_stride = s;
    @(negedge clk);
    ld_vld = 1'b0; ld_promise = 1'b0;
  endtask

  task automatic miss(logic [TAG_W-1:0] tag);
    mem_miss_vld = 1'b1; mem_miss_tag = tag;
    @(negedge clk);
    mem_miss_vld = 1'b0;
  endtask

  task automatic ret(logic [TAG_W-1:0] tag);
    mem_ret_vld = 1'b1; mem_ret_tag = tag;
    @(negedge clk);
    mem_ret_vld = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 halt low in reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 halt low after reset", 1'b0);
    miss(4'd0);
    chk("R1 no tag predicted after reset", 1'b0);
  endtask

  task automatic t_basic();
    issue(32'h100, 4'd1, 1'b1, 4'd0);
    chk("R4 prediction alone no halt", 1'b0);
    miss(4'd1);
    chk("R4 halt after predicted miss", 1'b1);
    @(negedge clk);
    chk("R5 halt held while outstanding", 1'b1);
    ret(4'd1);
    chk("R5 halt drops after return", 1'b0);
  endtask

  task automatic t_unmarked();
    issue(32'h200, 4'd2, 1'b0, 4'd0);
    miss(4'd2);
    chk("R2 unmarked load miss ignored", 1'b0);
  endtask

  task automatic t_wrong_tag();
    issue(32'h300, 4'd3, 1'b1, 4'd0);
    miss(4'd4);
    chk("R4 miss on other tag ignored", 1'b0);
    miss(4'd3);
    chk("R4 predicted tag still halts", 1'b1);
    ret(4'd3);
    chk("R5 release after wrong-tag case", 1'b0);
  endtask

  task automatic t_stride();
    issue(32'h400, 4'd5, 1'b1, 4'd2);
    miss(4'd5);
    chk("R3 stride2 exec1 not predicted", 1'b0);
    issue(32'h400, 4'd6, 1'b1, 4'd2);
    miss(4'd6);
    chk("R3 stride2 exec2 not predicted", 1'b0);
    issue(32'h400, 4'd7, 1'b1, 4'd2);
    miss(4'd7);
    chk("R3 stride2 exec3 predicted", 1'b1);
    ret(4'd7);
    issue(32'h400, 4'd8, 1'b1, 4'd2);
    miss(4'd8);
    chk("R3 counter restarted after prediction", 1'b0);
  endtask

  task automatic t_multi();
    issue(32'h100, 4'd9, 1'b1, 4'd0);
    issue(32'h300, 4'd10, 1'b1, 4'd0);
    miss(4'd9);
    miss(4'd10);
    chk("R6 two misses outstanding", 1'b1);
    ret(4'd9);
    chk("R6 held after first return", 1'b1);
    ret(4'd11);
    chk("R6 stray return ignored", 1'b1);
    ret(4'd10);
    chk("R6 released after last return", 1'b0);
  endtask

  task automatic t_flush();
    issue(32'h100, 4'd12, 1'b1, 4'd0);
    issue(32'h100, 4'd13, 1'b1, 4'd0);
    miss(4'd12);
    chk("R7 halted before flush", 1'b1);
    do_flush();
    chk("R7 flush drops halt", 1'b0);
    ret(4'd12);
    chk("R7 late return after flush ignored", 1'b0);
    miss(4'd13);
    chk("R7 flush cleared predictions", 1'b0);
    issue(32'h400, 4'd14, 1'b1, 4'd2);
    miss(4'd14);
    chk("R7 table counter kept across flush", 1'b0);
  endtask

  task automatic t_lru();
    t_reset();
    for (int i = 0; i < 8; i++) issue(32'h1000 + 32'(i * 4), 4'd0, 1'b1, 4'd2);
    issue(32'h1000, 4'd0, 1'b1, 4'd2);
    issue(32'h1020, 4'd0, 1'b1, 4'd2);
    issue(32'h1004, 4'd1, 1'b1, 4'd2);
    issue(32'h1004, 4'd2, 1'b1, 4'd2);
    miss(4'd2);
    chk("R8 LRU entry was evicted", 1'b0);
    issue(32'h1000, 4'd3, 1'b1, 4'd2);
    miss(4'd3);
    chk("R8 recently used entry retained", 1'b1);
    ret(4'd3);
    chk("R8 release after LRU case", 1'b0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_unmarked();
    t_wrong_tag();
    t_stride();
    t_multi();
    t_flush();
    t_lru();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule